// File: doc/BRIEF.md
# Dual-Window Boot Flash Address Decoder

This block turns 32-bit host read addresses into byte offsets within a boot flash device, for boot regions that can exceed 16MiB. A single init strobe supplies the region's starting offset in flash and its length. The block then derives two decode windows. The fixed window always ends at the 4GiB host boundary and covers the top of the region. The extended window is used only when the region is longer than the fixed window can hold. It sits at the top of a host range whose base and maximum length are set by parameters, and it covers the part of the region directly below the fixed window's part.

Lookups arrive on a valid/ready handshake. Each accepted address produces one response, one clock later, with a hit flag, the window that matched and the translated flash offset. A status output gives the extended window's current host base and length, and gives zero for both when that window is unused. The windows are fixed by the first init after reset; later init strobes change nothing. The two extended-range parameters must be nonzero, and elaboration stops if either is zero.

Top module: `flash_window_decoder`

## Requirements
- R1: The fixed window's length is the smaller of 16MiB and the region length. Its host base is 2^32 minus that length, so its last byte is host address 0xFFFFFFFF.
- R2: The fixed window covers the top of the region: its flash base is region start + region length − fixed length.
- R3: The extended length is the smaller of EXT_MAX and (region length − fixed length). An extended length of zero disables the extended window, and its addresses then miss.
- R4: The extended window's host base is EXT_BASE + EXT_MAX − extended length. Addresses in the reserved range below that base miss.
- R5: The extended window's flash base is the fixed flash base minus the extended length, so its flash range lies directly below the fixed one.
- R6: An address inside a window's host range gives rsp_hit=1 and rsp_offset = window flash base + (address − window host base). rsp_win is 0 for the fixed window and 1 for the extended window. If the windows overlap, the fixed window wins.
- R7: An address outside both windows gives rsp_hit=0, rsp_win=0 and rsp_offset=0.
- R8: Only the first init after reset sets the windows. Later init strobes leave translations and status unchanged until the next reset.
- R9: ext_base and ext_size report the extended window's host base and length. Both read zero when the extended window is disabled and before init.
- R10: Before the first init, every lookup misses.
- R11: req_ready rises once reset has been released internally. Each cycle with req_valid and req_ready high produces a response with rsp_valid high in the next cycle, and only then. Back-to-back requests give back-to-back responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Strobe that sets the windows (first one only) |
| region_start | input | 32 | Boot region start offset in flash |
| region_size | input | 32 | Boot region length in bytes |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_addr | input | 32 | Host address to translate |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_hit | output | 1 | Address fell in a window |
| rsp_win | output | 1 | Matching window: 0 fixed, 1 extended |
| rsp_offset | output | 32 | Translated flash offset, zero on a miss |
| ext_base | output | 32 | Extended window host base, zero if unused |
| ext_size | output | 32 | Extended window length, zero if unused |

## Verification
The bench probes the first and last byte of each window and the byte just outside each one. A design off by one in the range compare would hit outside a window or miss its edge byte. It uses a region of exactly 16MiB, where the extended length comes out zero. A design that mishandled this case would enable an empty window or report a nonzero status. It also uses a region large enough that EXT_MAX caps the extended length. A design that ignored the cap would shift the extended host base below EXT_BASE. Finally, a second init is sent after the windows are set, and a design that re-latched on it would change the status and the translations.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned HOST_W = 32;
  localparam int unsigned WIDE_W = HOST_W + 1;
  localparam logic [WIDE_W-1:0] TOP_4G = {1'b1, {HOST_W{1'b0}}};
  localparam int unsigned N_WIN = 2;

  typedef enum logic {
    WIN_FIXED = 1'b0,
    WIN_EXT   = 1'b1
  } win_id_e;

  typedef struct packed {
    logic              en;
    logic [WIDE_W-1:0] host_base;
    logic [WIDE_W-1:0] size;
    logic [HOST_W-1:0] flash_base;
  } win_t;

  function automatic logic [WIDE_W-1:0] min_wide(input logic [WIDE_W-1:0] a,
                                                 input logic [WIDE_W-1:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/fwd_rst_sync.sv
module fwd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fwd_window_calc.sv
module fwd_window_calc
  import fwd_pkg::*;
#(
  parameter logic [WIDE_W-1:0] FIXED_MAX = 33'h0_0100_0000,
  parameter logic [HOST_W-1:0] EXT_BASE  = 32'hF800_0000,
  parameter logic [HOST_W-1:0] EXT_MAX   = 32'h0200_0000
) (
  input  logic [HOST_W-1:0] region_start,
  input  logic [HOST_W-1:0] region_size,
  output win_t              fixed_w,
  output win_t              ext_w
);
  logic [WIDE_W-1:0] size_w;
  logic [WIDE_W-1:0] fix_len;
  logic [WIDE_W-1:0] rest_len;
  logic [WIDE_W-1:0] ext_len;
  logic [WIDE_W-1:0] ext_top;
  logic [HOST_W-1:0] fix_flash;

  always_comb begin
    size_w    = {1'b0, region_size};
    fix_len   = min_wide(size_w, FIXED_MAX);
    fix_flash = region_start + region_size - fix_len[HOST_W-1:0];
    rest_len  = size_w - fix_len;
    ext_len   = min_wide(rest_len, {1'b0, EXT_MAX});
    ext_top   = {1'b0, EXT_BASE} + {1'b0, EXT_MAX};

    fixed_w.en         = (fix_len != '0);
    fixed_w.size       = fix_len;
    fixed_w.host_base  = TOP_4G - fix_len;
    fixed_w.flash_base = fix_flash;

    ext_w.en         = (ext_len != '0);
    ext_w.size       = ext_len;
    ext_w.host_base  = ext_w.en ? (ext_top - ext_len) : '0;
    ext_w.flash_base = ext_w.en ? (fix_flash - ext_len[HOST_W-1:0]) : '0;
  end
endmodule

// File: rtl/fwd_cfg_regs.sv
module fwd_cfg_regs
  import fwd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_req,
  input  win_t fixed_in,
  input  win_t ext_in,
  output win_t fixed_q,
  output win_t ext_q,
  output logic done_q
);
  logic capture;
  logic done_d;

  always_comb begin
    capture = init_req && !done_q;
    done_d  = done_q || capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      fixed_q <= '0;
      ext_q   <= '0;
    end else begin
      done_q <= done_d;
      if (capture) begin
        fixed_q <= fixed_in;
        ext_q   <= ext_in;
      end
    end
  end
endmodule

// File: rtl/fwd_window_match.sv
module fwd_window_match
  import fwd_pkg::*;
(
  input  win_t              win,
  input  logic [HOST_W-1:0] addr,
  output logic              hit,
  output logic [HOST_W-1:0] offset
);
  logic [WIDE_W-1:0] addr_w;
  logic [WIDE_W-1:0] win_end;
  logic [WIDE_W-1:0] rel;

  always_comb begin
    addr_w  = {1'b0, addr};
    win_end = win.host_base + win.size;
    rel     = addr_w - win.host_base;
    hit     = win.en && (addr_w >= win.host_base) && (addr_w < win_end);
    offset  = win.flash_base + rel[HOST_W-1:0];
  end
endmodule

// File: rtl/flash_window_decoder.sv
module flash_window_decoder
  import fwd_pkg::*;
#(
  parameter logic [WIDE_W-1:0] FIXED_MAX = 33'h0_0100_0000,
  parameter logic [HOST_W-1:0] EXT_BASE  = 32'hF800_0000,
  parameter logic [HOST_W-1:0] EXT_MAX   = 32'h0200_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  input  logic [HOST_W-1:0] region_start,
  input  logic [HOST_W-1:0] region_size,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [HOST_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_win,
  output logic [HOST_W-1:0] rsp_offset,
  output logic [HOST_W-1:0] ext_base,
  output logic [HOST_W-1:0] ext_size
);
  generate
    if (EXT_BASE == '0 || EXT_MAX == '0) begin : g_bad_cfg
      $error("flash_window_decoder: EXT_BASE and EXT_MAX must both be nonzero");
    end
  endgenerate

  logic rst_n_int;
  win_t calc_fixed, calc_ext;
  win_t cfg_fixed, cfg_ext;
  logic cfg_done;
  win_t wins [N_WIN];
  logic [N_WIN-1:0]  win_hit;
  logic [HOST_W-1:0] win_off [N_WIN];

  fwd_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  fwd_window_calc #(
    .FIXED_MAX (FIXED_MAX),
    .EXT_BASE  (EXT_BASE),
    .EXT_MAX   (EXT_MAX)
  ) u_calc (
    .region_start (region_start),
    .region_size  (region_size),
    .fixed_w      (calc_fixed),
    .ext_w        (calc_ext)
  );

  fwd_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .init_req (init_req),
    .fixed_in (calc_fixed),
    .ext_in   (calc_ext),
    .fixed_q  (cfg_fixed),
    .ext_q    (cfg_ext),
    .done_q   (cfg_done)
  );

  always_comb begin
    wins[WIN_FIXED] = cfg_fixed;
    wins[WIN_EXT]   = cfg_ext;
  end

  for (genvar g = 0; g < N_WIN; g++) begin : g_match
    fwd_window_match u_match (
      .win    (wins[g]),
      .addr   (req_addr),
      .hit    (win_hit[g]),
      .offset (win_off[g])
    );
  end

  // Response path: next-state logic, then registers.
  logic              ready_q;
  logic              accept;
  logic              vld_q, vld_d;
  logic              hit_q, hit_d;
  logic              win_q, win_d;
  logic [HOST_W-1:0] off_q, off_d;

  always_comb begin
    accept = req_valid && ready_q;
    vld_d  = accept;
    hit_d  = 1'b0;
    win_d  = WIN_FIXED;
    off_d  = '0;
    if (cfg_done) begin
      if (win_hit[WIN_FIXED]) begin
        hit_d = 1'b1;
        win_d = WIN_FIXED;
        off_d = win_off[WIN_FIXED];
      end else if (win_hit[WIN_EXT]) begin
        hit_d = 1'b1;
        win_d = WIN_EXT;
        off_d = win_off[WIN_EXT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ready_q <= 1'b0;
      vld_q   <= 1'b0;
      hit_q   <= 1'b0;
      win_q   <= 1'b0;
      off_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      vld_q   <= vld_d;
      if (accept) begin
        hit_q <= hit_d;
        win_q <= win_d;
        off_q <= off_d;
      end
    end
  end

  assign req_ready  = ready_q;
  assign rsp_valid  = vld_q;
  assign rsp_hit    = hit_q;
  assign rsp_win    = win_q;
  assign rsp_offset = off_q;
  assign ext_base   = cfg_ext.host_base[HOST_W-1:0];
  assign ext_size   = cfg_ext.size[HOST_W-1:0];
endmodule

// File: rtl/fwd_decoder_checks.sv
module fwd_decoder_checks #(
  parameter logic [31:0] EXT_BASE = 32'hF800_0000,
  parameter logic [31:0] EXT_MAX  = 32'h0200_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic        rsp_win,
  input logic [31:0] rsp_offset,
  input logic [31:0] ext_base,
  input logic [31:0] ext_size,
  input logic        cfg_done
);
  // R11: accepted request gives a response next cycle
  a_r11_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R11: no response without an accepted request
  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);
  // R10: lookups before init miss
  a_r10_preinit_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_done) |=> !rsp_hit);
  // R7: a miss carries zero offset and window 0
  a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_offset == 32'h0 && !rsp_win));
  // R8: once set, the windows stay put
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> (cfg_done && $stable(ext_base) && $stable(ext_size)));
  // R9: unused extended window reports zero base
  a_r9_zero_status: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_size == 32'h0) |-> (ext_base == 32'h0));
  // R3: extended length never exceeds its cap
  a_r3_ext_capped: assert property (@(posedge clk) disable iff (!rst_n)
    ext_size <= EXT_MAX);
  // R4: a used extended window sits inside the reserved range
  a_r4_ext_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_size != 32'h0) |-> ({1'b0, ext_base} >= {1'b0, EXT_BASE} &&
      ({1'b0, ext_base} + {1'b0, ext_size}) == ({1'b0, EXT_BASE} + {1'b0, EXT_MAX})));
endmodule

bind flash_window_decoder fwd_decoder_checks #(
  .EXT_BASE (EXT_BASE),
  .EXT_MAX  (EXT_MAX)
) u_fwd_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_win    (rsp_win),
  .rsp_offset (rsp_offset),
  .ext_base   (ext_base),
  .ext_size   (ext_size),
  .cfg_done   (cfg_done)
);

// File: tb/test_flash_window_decoder.sv
`timescale 1ns/1ps
module test_flash_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_req = 1'b0;
  logic [31:0] region_start = '0;
  logic [31:0] region_size = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_win;
  logic [31:0] rsp_offset, ext_base, ext_size;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  flash_window_decoder i_flash_window_decoder (
    .clk(clk), .rst_n(rst_n), .init_req(init_req),
    .region_start(region_start), .region_size(region_size),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
    .rsp_offset(rsp_offset), .ext_base(ext_base), .ext_size(ext_size)
  );

  typedef struct packed {
    logic [31:0] start;
    logic [31:0] size;
    logic [31:0] addr;
    logic        hit;
    logic        win;
    logic [31:0] off;
    logic [31:0] xbase;
    logic [31:0] xsize;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // 8MiB region: fixed window only (R1 R2), extended disabled (R3)
    '{32'h0000_1000, 32'h0080_0000, 32'hFF80_0000, 1'b1, 1'b0, 32'h0000_1000, 32'h0, 32'h0},
    '{32'h0000_1000, 32'h0080_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h0080_0FFF, 32'h0, 32'h0},
    '{32'h0000_1000, 32'h0080_0000, 32'hFF7F_FFFF, 1'b0, 1'b0, 32'h0,         32'h0, 32'h0},
    '{32'h0000_1000, 32'h0080_0000, 32'hF900_0000, 1'b0, 1'b0, 32'h0,         32'h0, 32'h0},
    // 32MiB region: extended 16MiB at top of reserved range (R4 R5)
    '{32'h0040_0000, 32'h0200_0000, 32'hF900_0000, 1'b1, 1'b1, 32'h0040_0000, 32'hF900_0000, 32'h0100_0000},
    '{32'h0040_0000, 32'h0200_0000, 32'hF9FF_FFFF, 1'b1, 1'b1, 32'h013F_FFFF, 32'hF900_0000, 32'h0100_0000},
    '{32'h0040_0000, 32'h0200_0000, 32'hF8FF_FFFF, 1'b0, 1'b0, 32'h0,         32'hF900_0000, 32'h0100_0000},
    '{32'h0040_0000, 32'h0200_0000, 32'hFA00_0000, 1'b0, 1'b0, 32'h0,         32'hF900_0000, 32'h0100_0000},
    '{32'h0040_0000, 32'h0200_0000, 32'hFF00_0000, 1'b1, 1'b0, 32'h0140_0000, 32'hF900_0000, 32'h0100_0000},
    '{32'h0040_0000, 32'h0200_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h023F_FFFF, 32'hF900_0000, 32'h0100_0000},
    '{32'h0040_0000, 32'h0200_0000, 32'hFEFF_FFFF, 1'b0, 1'b0, 32'h0,         32'hF900_0000, 32'h0100_0000},
    // 64MiB region: extended length capped at 32MiB (R3 R4 R5)
    '{32'h0000_0000, 32'h0400_0000, 32'hF800_0000, 1'b1, 1'b1, 32'h0100_0000, 32'hF800_0000, 32'h0200_0000},
    '{32'h0000_0000, 32'h0400_0000, 32'hF7FF_FFFF, 1'b0, 1'b0, 32'h0,         32'hF800_0000, 32'h0200_0000},
    '{32'h0000_0000, 32'h0400_0000, 32'hF9FF_FFFF, 1'b1, 1'b1, 32'h02FF_FFFF, 32'hF800_0000, 32'h0200_0000},
    '{32'h0000_0000, 32'h0400_0000, 32'hFF80_0000, 1'b1, 1'b0, 32'h0380_0000, 32'hF800_0000, 32'h0200_0000},
    // exactly 16MiB: extended length zero (R1 R3 R9)
    '{32'h0010_0000, 32'h0100_0000, 32'hFF00_0000, 1'b1, 1'b0, 32'h0010_0000, 32'h0, 32'h0},
    '{32'h0010_0000, 32'h0100_0000, 32'hFEFF_FFFF, 1'b0, 1'b0, 32'h0,         32'h0, 32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 10 && !req_ready; k++) @(negedge clk);
  endtask

  task automatic do_init(input logic [31:0] s, input logic [31:0] z);
    @(negedge clk);
    region_start = s;
    region_size  = z;
    init_req     = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a, output logic v, output logic h,
                        output logic w, output logic [31:0] o);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    v = rsp_valid; h = rsp_hit; w = rsp_win; o = rsp_offset;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic v, h, w;
    logic [31:0] o;
    logic [63:0] cur;

    // Reset state (R11, R9)
    do_reset();
    check("R11 ready after reset", {31'h0, req_ready}, 32'h1);
    check("R11 no rsp at reset", {31'h0, rsp_valid}, 32'h0);
    check("R9 ext_base pre-init", ext_base, 32'h0);
    check("R9 ext_size pre-init", ext_size, 32'h0);
    // R10: pre-init lookup at the top of the fixed window misses
    lookup(32'hFFFF_FFFF, v, h, w, o);
    check("R11 rsp_valid", {31'h0, v}, 32'h1);
    check("R10 pre-init hit", {31'h0, h}, 32'h0);
    check("R10 pre-init offset", o, 32'h0);

    cur = '1;
    for (int i = 0; i < NV; i++) begin
      if ({VECS[i].start, VECS[i].size} != cur) begin
        cur = {VECS[i].start, VECS[i].size};
        do_reset();
        do_init(VECS[i].start, VECS[i].size);
        check("R9 ext_base", ext_base, VECS[i].xbase);
        check("R9 ext_size", ext_size, VECS[i].xsize);
      end
      lookup(VECS[i].addr, v, h, w, o);
      check("R11 rsp_valid", {31'h0, v}, 32'h1);
      check(VECS[i].hit ? "R6 hit" : "R7 hit", {31'h0, h}, {31'h0, VECS[i].hit});
      check(VECS[i].hit ? "R6 win" : "R7 win", {31'h0, w}, {31'h0, VECS[i].win});
      check(VECS[i].hit ? "R6 offset" : "R7 offset", o, VECS[i].off);
    end

    // R8: second init (would enable a capped extended window) is ignored
    do_init(32'h0000_0000, 32'h0400_0000);
    check("R8 ext_size kept", ext_size, 32'h0);
    check("R8 ext_base kept", ext_base, 32'h0);
    lookup(32'hFF00_0000, v, h, w, o);
    check("R8 offset kept", o, 32'h0010_0000);
    lookup(32'hF800_0000, v, h, w, o);
    check("R8 ext still off", {31'h0, h}, 32'h0);

    // R11: back-to-back requests give back-to-back responses
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'hFF00_0000;
    @(negedge clk);
    req_addr = 32'hFF00_0010;
    check("R11 b2b first valid", {31'h0, rsp_valid}, 32'h1);
    check("R11 b2b first offset", rsp_offset, 32'h0010_0000);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 b2b second valid", {31'h0, rsp_valid}, 32'h1);
    check("R11 b2b second offset", rsp_offset, 32'h0010_0010);
    @(negedge clk);
    check("R11 idle no rsp", {31'h0, rsp_valid}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule